// File: doc/BRIEF.md
# Ring-Buffer Transfer Block Pointer

This block tracks which buffer RAM block is next in line for transfer to the host. It holds a 9-bit block pointer and a separate start offset inside that block. The pointer stays inside a transfer ring whose first and last blocks are set by software. It can step forward by one block when a transfer ends, or jump ahead by a skip count N. A jump also takes N off a remaining transfer count.

A comparator watches the block number that the buffering side is filling. When that number reaches a programmed target, it raises a sticky stop flag. All settings are reached over a simple register bus. Writes take effect at the clock edge. A read returns its data one cycle after the address is presented.

Register addresses on `wr_addr`/`rd_addr`: 0 pointer, 1 offset, 2 ring first block, 3 ring last block, 4 remaining count, 5 skip N, 6 target block, 7 mode, 8 status. Mode bits: bit0 auto, bit1 data-in disable, bit2 latch mode, bit3 compare enable, bit4 compare select. Status bit0 is the stop flag.

Top module: `xfer_blk_ptr`

## Requirements
- R1: After a synchronous reset, the pointer, offset, ring bounds, count, skip, target, mode and stop flag are all zero.
- R2: A write to addresses 0..8 updates the named register at the clock edge. A read of those addresses returns the zero-extended value on `rd_data` one cycle after `rd_addr` is presented. Any other address reads as zero.
- R3: A `xfer_done` pulse advances the pointer by one only when mode bit0 is 1, bit1 is 0 and bit2 is 0.
- R4: In every other mode, `xfer_done` leaves the pointer unchanged. With no write and no `xfer_done`, the pointer also holds.
- R5: A move of S blocks gives ring_first + ((pointer − ring_first + S) mod (ring_last − ring_first + 1)). A pointer at the last block that advances by one goes to the first block.
- R6: With mode bit0 set, a write of N to address 5 moves the pointer by N under R5. In the same edge, the remaining count drops by N.
- R7: With mode bit0 clear, a write to address 5 changes neither the pointer nor the count.
- R8: When N is at least the remaining count, the count becomes zero instead of wrapping.
- R9: When an advancing `xfer_done` and an accepted skip write fall in the same cycle, the pointer moves by N+1.
- R10: With mode bit3 set and bit4 clear, `buf_blk` equal to the target sets `buf_stop` at the next edge. The flag then stays set.
- R11: Writing status with bit0 = 1 clears `buf_stop`. If the set condition holds in the same cycle, the flag stays set.
- R12: With mode bit4 set, a match does not set `buf_stop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read register address |
| xfer_done | input | 1 | One-cycle end-of-transfer pulse |
| buf_blk | input | 9 | Block number now being buffered |
| cur_blk | output | 9 | Next block to transfer |
| cur_ofs | output | 12 | Start offset inside that block |
| remain_cnt | output | 16 | Remaining transfer count |
| buf_stop | output | 1 | Sticky buffering-stop flag |
| rd_data | output | 16 | Registered read data |

## Verification
The bench pushes the pointer across the last ring block, both by a single advance and by a multi-block skip. A design without modulo wrapping would run the pointer out of the ring into unrelated blocks.

It sets each of the three mode bits that must block an advance, in turn. A design that tests only the auto bit would move the pointer during a latched or data-in-disabled transfer.

It issues a skip larger than the remaining count. An unsaturated subtraction would leave a huge count instead of zero.

It also collides an end-of-transfer with a skip. It collides a status clear with a live target match. A design with the wrong priority would lose one block of movement in the first case and drop the stop flag in the second.

// File: rtl/xbp_pkg.sv
package xbp_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_PTR    = 4'd0,
    RA_OFS    = 4'd1,
    RA_RFIRST = 4'd2,
    RA_RLAST  = 4'd3,
    RA_CNT    = 4'd4,
    RA_SKIP   = 4'd5,
    RA_TGT    = 4'd6,
    RA_MODE   = 4'd7,
    RA_STAT   = 4'd8
  } reg_addr_e;

  typedef struct packed {
    logic cmp_sel;
    logic cmp_en;
    logic latch_mode;
    logic din_dis;
    logic auto_en;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/xbp_regfile.sv
module xbp_regfile
  import xbp_pkg::*;
#(
  parameter int BLK_W  = 9,
  parameter int OFS_W  = 12,
  parameter int CNT_W  = 16,
  parameter int SKIP_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [BLK_W-1:0]  ptr_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              stop_q,
  output logic [OFS_W-1:0]  ofs_q,
  output logic [BLK_W-1:0]  rfirst_q,
  output logic [BLK_W-1:0]  rlast_q,
  output logic [SKIP_W-1:0] skip_q,
  output logic [BLK_W-1:0]  tgt_q,
  output mode_t             mode_q,
  output logic              wr_ptr,
  output logic              wr_cnt,
  output logic              wr_skip,
  output logic              clr_stop,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    wr_ptr   = wr_en && (wr_addr == RA_PTR);
    wr_cnt   = wr_en && (wr_addr == RA_CNT);
    wr_skip  = wr_en && (wr_addr == RA_SKIP);
    clr_stop = wr_en && (wr_addr == RA_STAT) && wr_data[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_q    <= '0;
      rfirst_q <= '0;
      rlast_q  <= '0;
      skip_q   <= '0;
      tgt_q    <= '0;
      mode_q   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        RA_OFS:    ofs_q    <= wr_data[OFS_W-1:0];
        RA_RFIRST: rfirst_q <= wr_data[BLK_W-1:0];
        RA_RLAST:  rlast_q  <= wr_data[BLK_W-1:0];
        RA_SKIP:   skip_q   <= wr_data[SKIP_W-1:0];
        RA_TGT:    tgt_q    <= wr_data[BLK_W-1:0];
        RA_MODE:   mode_q   <= mode_t'(wr_data[MODE_W-1:0]);
        default:   ;
      endcase
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    case (rd_addr)
      RA_PTR:    rd_mux = DATA_W'(ptr_q);
      RA_OFS:    rd_mux = DATA_W'(ofs_q);
      RA_RFIRST: rd_mux = DATA_W'(rfirst_q);
      RA_RLAST:  rd_mux = DATA_W'(rlast_q);
      RA_CNT:    rd_mux = DATA_W'(cnt_q);
      RA_SKIP:   rd_mux = DATA_W'(skip_q);
      RA_TGT:    rd_mux = DATA_W'(tgt_q);
      RA_MODE:   rd_mux = DATA_W'(mode_q);
      RA_STAT:   rd_mux = DATA_W'(stop_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/xbp_ring_step.sv
module xbp_ring_step #(
  parameter int BLK_W  = 9,
  parameter int STEP_W = 9
) (
  input  logic [BLK_W-1:0]  ptr,
  input  logic [BLK_W-1:0]  ring_first,
  input  logic [BLK_W-1:0]  ring_last,
  input  logic [STEP_W-1:0] step,
  output logic [BLK_W-1:0]  nxt
);
  localparam int SUM_W = BLK_W + STEP_W + 1;

  logic [BLK_W:0]   len;
  logic [BLK_W-1:0] rel;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] wrapped;

  always_comb begin
    len     = {1'b0, ring_last} - {1'b0, ring_first} + (BLK_W+1)'(1);
    rel     = ptr - ring_first;
    sum     = SUM_W'(rel) + SUM_W'(step);
    wrapped = '0;
    if (len == '0) begin
      nxt = ptr + BLK_W'(step);
    end else begin
      wrapped = sum % SUM_W'(len);
      nxt     = ring_first + wrapped[BLK_W-1:0];
    end
  end
endmodule

// File: rtl/xbp_stop_cmp.sv
module xbp_stop_cmp #(
  parameter int BLK_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_en,
  input  logic             cmp_sel,
  input  logic [BLK_W-1:0] buf_blk,
  input  logic [BLK_W-1:0] tgt,
  input  logic             clr,
  output logic             stop_q
);
  logic hit;
  assign hit = cmp_en && !cmp_sel && (buf_blk == tgt);

  always_ff @(posedge clk) begin
    if (rst)      stop_q <= 1'b0;
    else if (hit) stop_q <= 1'b1;
    else if (clr) stop_q <= 1'b0;
  end
endmodule

// File: rtl/xfer_blk_ptr.sv
module xfer_blk_ptr
  import xbp_pkg::*;
#(
  parameter int BLK_W  = 9,
  parameter int OFS_W  = 12,
  parameter int CNT_W  = 16,
  parameter int SKIP_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [3:0]        rd_addr,
  input  logic              xfer_done,
  input  logic [BLK_W-1:0]  buf_blk,
  output logic [BLK_W-1:0]  cur_blk,
  output logic [OFS_W-1:0]  cur_ofs,
  output logic [CNT_W-1:0]  remain_cnt,
  output logic              buf_stop,
  output logic [DATA_W-1:0] rd_data
);
  localparam int STEP_W = SKIP_W + 1;

  logic [BLK_W-1:0]  ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              stop_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [BLK_W-1:0]  rfirst_q;
  logic [BLK_W-1:0]  rlast_q;
  logic [SKIP_W-1:0] skip_q;
  logic [BLK_W-1:0]  tgt_q;
  mode_t             mode_q;
  logic              wr_ptr;
  logic              wr_cnt;
  logic              wr_skip;
  logic              clr_stop;

  logic auto_en, din_dis, latch_mode, cmp_en, cmp_sel;
  assign auto_en    = mode_q.auto_en;
  assign din_dis    = mode_q.din_dis;
  assign latch_mode = mode_q.latch_mode;
  assign cmp_en     = mode_q.cmp_en;
  assign cmp_sel    = mode_q.cmp_sel;

  xbp_regfile #(
    .BLK_W(BLK_W), .OFS_W(OFS_W), .CNT_W(CNT_W),
    .SKIP_W(SKIP_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .ptr_q(ptr_q),
    .cnt_q(cnt_q), .stop_q(stop_q), .ofs_q(ofs_q),
    .rfirst_q(rfirst_q), .rlast_q(rlast_q), .skip_q(skip_q),
    .tgt_q(tgt_q), .mode_q(mode_q), .wr_ptr(wr_ptr),
    .wr_cnt(wr_cnt), .wr_skip(wr_skip), .clr_stop(clr_stop),
    .rd_data(rd_data)
  );

  // advance and skip qualification
  logic              inc_go;
  logic              skip_go;
  logic [SKIP_W-1:0] skip_n;
  logic [STEP_W-1:0] step;
  logic [BLK_W-1:0]  ptr_nxt;

  always_comb begin
    inc_go  = xfer_done && auto_en && !din_dis && !latch_mode;
    skip_go = wr_skip && auto_en;
    skip_n  = wr_data[SKIP_W-1:0];
    step    = (skip_go ? STEP_W'(skip_n) : '0) + STEP_W'(inc_go);
  end

  xbp_ring_step #(.BLK_W(BLK_W), .STEP_W(STEP_W)) u_step (
    .ptr(ptr_q), .ring_first(rfirst_q), .ring_last(rlast_q),
    .step(step), .nxt(ptr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)                ptr_q <= '0;
    else if (wr_ptr)        ptr_q <= wr_data[BLK_W-1:0];
    else if (step != '0)    ptr_q <= ptr_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (wr_cnt)   cnt_q <= wr_data[CNT_W-1:0];
    else if (skip_go) begin
      if (cnt_q > CNT_W'(skip_n)) cnt_q <= cnt_q - CNT_W'(skip_n);
      else                        cnt_q <= '0;
    end
  end

  xbp_stop_cmp #(.BLK_W(BLK_W)) u_stop (
    .clk(clk), .rst(rst), .cmp_en(cmp_en), .cmp_sel(cmp_sel),
    .buf_blk(buf_blk), .tgt(tgt_q), .clr(clr_stop), .stop_q(stop_q)
  );

  assign cur_blk    = ptr_q;
  assign cur_ofs    = ofs_q;
  assign remain_cnt = cnt_q;
  assign buf_stop   = stop_q;
endmodule

// File: rtl/xbp_checker.sv
module xbp_checker #(
  parameter int BLK_W  = 9,
  parameter int CNT_W  = 16,
  parameter int SKIP_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [3:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              xfer_done,
  input logic [BLK_W-1:0]  buf_blk,
  input logic [BLK_W-1:0]  cur_blk,
  input logic [CNT_W-1:0]  remain_cnt,
  input logic              buf_stop,
  input logic              auto_en,
  input logic              din_dis,
  input logic              latch_mode,
  input logic              cmp_en,
  input logic              cmp_sel,
  input logic [BLK_W-1:0]  tgt,
  input logic [BLK_W-1:0]  rfirst,
  input logic [BLK_W-1:0]  rlast
);
  logic adv_ok;
  logic in_ring;
  assign adv_ok  = auto_en && !din_dis && !latch_mode;
  assign in_ring = (rfirst <= rlast) && (cur_blk >= rfirst) && (cur_blk <= rlast);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !xfer_done) |=> $stable(cur_blk)); // R4
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !wr_en && !adv_ok) |=> $stable(cur_blk)); // R4
  AST_ADVANCE_ONE: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !wr_en && adv_ok && in_ring && cur_blk < rlast)
      |=> cur_blk == BLK_W'($past(cur_blk) + 1'b1)); // R3
  AST_RING_STAY: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !wr_en && adv_ok && in_ring)
      |=> (cur_blk >= rfirst && cur_blk <= rlast)); // R5
  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 4'd5 && auto_en && remain_cnt <= CNT_W'(wr_data[SKIP_W-1:0]))
      |=> remain_cnt == '0); // R8
  AST_STOP_SET: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && !cmp_sel && buf_blk == tgt) |=> buf_stop); // R10
  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (buf_stop && !(wr_en && wr_addr == 4'd8 && wr_data[0])) |=> buf_stop); // R11
  AST_NO_STOP_SEL: assert property (@(posedge clk) disable iff (rst)
    (!buf_stop && (!cmp_en || cmp_sel)) |=> !buf_stop); // R12
endmodule

bind xfer_blk_ptr xbp_checker #(
  .BLK_W(BLK_W), .CNT_W(CNT_W), .SKIP_W(SKIP_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .xfer_done(xfer_done), .buf_blk(buf_blk),
  .cur_blk(cur_blk), .remain_cnt(remain_cnt), .buf_stop(buf_stop),
  .auto_en(auto_en), .din_dis(din_dis), .latch_mode(latch_mode),
  .cmp_en(cmp_en), .cmp_sel(cmp_sel), .tgt(tgt_q),
  .rfirst(rfirst_q), .rlast(rlast_q)
);

// File: tb/xfer_blk_ptr_test.sv
module xfer_blk_ptr_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic        xfer_done = 1'b0;
  logic [8:0]  buf_blk = '0;
  logic [8:0]  cur_blk;
  logic [11:0] cur_ofs;
  logic [15:0] remain_cnt;
  logic        buf_stop;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  xfer_blk_ptr uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .xfer_done(xfer_done),
    .buf_blk(buf_blk), .cur_blk(cur_blk), .cur_ofs(cur_ofs),
    .remain_cnt(remain_cnt), .buf_stop(buf_stop), .rd_data(rd_data)
  );

  // kind[46:45] 0 write, 1 done, 2 done+write | addr | data | exp ptr | exp cnt
  localparam int NV = 21;
  localparam logic [46:0] VEC [NV] = '{
    {2'd0, 4'd2, 16'd10,  9'd0,  16'd0},   // ring first 10
    {2'd0, 4'd3, 16'd13,  9'd0,  16'd0},   // ring last 13
    {2'd0, 4'd4, 16'd100, 9'd0,  16'd100}, // count load
    {2'd0, 4'd0, 16'd12,  9'd12, 16'd100}, // pointer load
    {2'd0, 4'd7, 16'd1,   9'd12, 16'd100}, // auto on
    {2'd1, 4'd0, 16'd0,   9'd13, 16'd100}, // R3 advance
    {2'd1, 4'd0, 16'd0,   9'd10, 16'd100}, // R5 wrap
    {2'd0, 4'd5, 16'd5,   9'd11, 16'd95},  // R6 skip 5
    {2'd2, 4'd5, 16'd2,   9'd10, 16'd93},  // R9 done+skip 2
    {2'd0, 4'd7, 16'd3,   9'd10, 16'd93},  // data-in disabled
    {2'd1, 4'd0, 16'd0,   9'd10, 16'd93},  // R4 hold
    {2'd0, 4'd7, 16'd5,   9'd10, 16'd93},  // latch mode
    {2'd1, 4'd0, 16'd0,   9'd10, 16'd93},  // R4 hold
    {2'd0, 4'd7, 16'd0,   9'd10, 16'd93},  // auto off
    {2'd0, 4'd5, 16'd3,   9'd10, 16'd93},  // R7 skip ignored
    {2'd1, 4'd0, 16'd0,   9'd10, 16'd93},  // R4 hold
    {2'd0, 4'd7, 16'd1,   9'd10, 16'd93},  // auto on
    {2'd0, 4'd4, 16'd2,   9'd10, 16'd2},   // small count
    {2'd0, 4'd5, 16'd7,   9'd13, 16'd0},   // R8 saturate, R5 multi-wrap
    {2'd0, 4'd2, 16'd12,  9'd13, 16'd0},   // shrink ring
    {2'd1, 4'd0, 16'd0,   9'd12, 16'd0}    // R5 wrap in new ring
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, input logic [31:0] exp, input string tag);
    rd_addr = a;
    @(negedge clk);
    check(tag, 32'(rd_data), exp);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 pointer", 32'(cur_blk), 0);
    check("R1 offset", 32'(cur_ofs), 0);
    check("R1 count", 32'(remain_cnt), 0);
    check("R1 stop", 32'(buf_stop), 0);
    do_read(4'd7, 0, "R1 mode readback");

    for (int i = 0; i < NV; i++) begin
      wr_en     = (VEC[i][46:45] != 2'd1);
      xfer_done = (VEC[i][46:45] != 2'd0);
      wr_addr   = VEC[i][44:41];
      wr_data   = VEC[i][40:25];
      @(negedge clk);
      wr_en = 1'b0; xfer_done = 1'b0;
      check($sformatf("table row %0d pointer", i), 32'(cur_blk), 32'(VEC[i][24:16]));
      check($sformatf("table row %0d count", i), 32'(remain_cnt), 32'(VEC[i][15:0]));
    end

    // R2 register readback and offset
    do_write(4'd1, 16'h0ABC);
    check("R2 offset output", 32'(cur_ofs), 32'h0ABC);
    do_read(4'd1, 32'h0ABC, "R2 offset readback");
    do_read(4'd0, 12, "R2 pointer readback");
    do_read(4'd3, 13, "R2 ring last readback");
    do_read(4'd7, 1, "R2 mode readback");
    do_read(4'd12, 0, "R2 unused address");

    // R10 stop set and sticky
    do_write(4'd6, 16'd7);
    do_write(4'd7, 16'd8);
    buf_blk = 9'd7;
    @(negedge clk);
    check("R10 stop set", 32'(buf_stop), 1);
    buf_blk = 9'd3;
    @(negedge clk);
    check("R10 stop sticky", 32'(buf_stop), 1);
    do_read(4'd8, 1, "R2 status readback");
    // R11 set wins over clear
    buf_blk = 9'd7;
    do_write(4'd8, 16'd1);
    check("R11 set beats clear", 32'(buf_stop), 1);
    buf_blk = 9'd3;
    do_write(4'd8, 16'd0);
    check("R11 zero bit no clear", 32'(buf_stop), 1);
    do_write(4'd8, 16'd1);
    check("R11 clear", 32'(buf_stop), 0);
    // R12 compare select blocks stop
    do_write(4'd7, 16'd24);
    buf_blk = 9'd7;
    @(negedge clk);
    @(negedge clk);
    check("R12 select high no stop", 32'(buf_stop), 0);

    // R1 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 pointer after reset", 32'(cur_blk), 0);
    check("R1 offset after reset", 32'(cur_ofs), 0);
    do_read(4'd2, 0, "R1 ring first after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule